// File: doc/BRIEF.md
# Multi-Plane NAND Page Program Sequencer

This block is a host-side controller that writes up to four pages of a NAND flash with a single programming operation. It uses one page in each of the device's four planes. For each plane picked by a 4-bit enable mask, visited from the lowest index to the highest, the block sends a page-load command, four address bytes and one full page of payload. The payload comes from a byte stream with a valid/ready handshake. Every plane except the highest selected one is closed with a dummy program command, which gives only a short busy period. The highest selected plane is closed with the true program command, which starts programming of all loaded pages. After each close the block waits on the ready/busy pin, with a timeout. When programming ends it reads the multi-plane status byte and reports pass or fail for each plane.

The pins toward the flash are reduced to single-cycle strobes: command, address, data write and status read. They come with one shared output byte and one input byte. A request names a block group, a page within the block, and an area pointer. The block number in plane p is group*4 + p, so the plane index is the block number modulo 4. A request that uses the middle-area pointer is refused, because that pointer cannot be used with multi-plane programming. A request with no plane selected is also refused.

Top module: `mpp_seq`

## Requirements
- R1: After reset, busy, done, s_ready and all four flash strobes are 0, and they stay 0 until start is asserted.
- R2: A start with area_ptr bit 0 set (value 1 or 3) gives done one cycle after start, with err = 2 and fail_mask = 0. No flash strobe is issued. This check takes priority over the mask check.
- R3: A start with a legal pointer and plane_mask = 0 gives done one cycle after start, with err = 1. No flash strobe is issued.
- R4: An accepted request issues one pointer command, 0x00 for area_ptr 0 or 0x50 for area_ptr 2. Then, for each selected plane in ascending index order, it issues command 0x80, four address strobes, PAGE_BYTES data strobes and one close command. At most one flash strobe is active in any cycle.
- R5: The close command is 0x11 for every selected plane except the highest selected one, and 0x10 for that plane.
- R6: The four address bytes of plane p are 0x00 (column), followed by the row low byte, middle byte and high byte. The row is blk_grp*128 + p*32 + page_idx: row bits [4:0] hold the page, bits [6:5] the plane, and the bits above hold the group.
- R7: A payload byte is taken only in a cycle with s_valid and s_ready both high. Each byte taken appears exactly once, in arrival order, on fl_io_out with fl_dat_we in the next cycle. Gaps in s_valid are allowed.
- R8: After each close command the block ignores fl_rdy for the first GUARD (2) cycles. It then issues no further strobe until fl_rdy has returned high.
- R9: After the final wait the block issues command 0x71 and one fl_rd strobe. It then raises a one-cycle done with err = 0, fail_mask = status bits [4:1] ANDed with the selected mask (plane p at bit p+1), and any_fail = status bit 0.
- R10: If fl_rdy stays low for TMO_CYC cycles of a wait, done is raised with err = 3, fail_mask = 0, and no status command is issued.
- R11: busy is high from an accepted start until the cycle of done. start is ignored while busy is high, and s_ready is high only while a page payload is being taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled while idle |
| plane_mask | input | NP | Planes to program, bit p = plane p |
| area_ptr | input | 2 | Area pointer: 0 first half, 2 spare area, 1 and 3 refused |
| blk_grp | input | GRP_W | Block group; block number = group*4 + plane |
| page_idx | input | PG_W | Page within the block |
| s_data | input | 8 | Payload stream byte |
| s_valid | input | 1 | Payload byte valid |
| s_ready | output | 1 | Block can take a payload byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 ok, 1 empty mask, 2 illegal pointer, 3 busy timeout |
| fail_mask | output | NP | Per-plane program failure, valid with done |
| any_fail | output | 1 | Status summary fail bit, valid with done |
| fl_cmd_we | output | 1 | Command byte strobe |
| fl_adr_we | output | 1 | Address byte strobe |
| fl_dat_we | output | 1 | Data byte strobe |
| fl_rd | output | 1 | Status read strobe |
| fl_io_out | output | 8 | Byte driven to the flash |
| fl_io_in | input | 8 | Status byte from the flash |
| fl_rdy | input | 1 | Ready/busy pin, 1 = ready |

## Verification
Two behaviours are hard to reach from the ports. The first is the guard window after a close command: a flash that lowers ready/busy at once would hide a missing guard. The bench's flash model therefore waits one extra cycle before pulling fl_rdy low, and it flags any strobe sent while a busy period is pending or running. The second is masking of the per-plane fail flags. The bench returns status bytes with fail bits set for planes that were not selected, uses sparse masks, and checks that only the selected planes' flags reach fail_mask. A timeout is forced by holding fl_rdy low after the true program command.

// File: rtl/mpp_pkg.sv
package mpp_pkg;

  localparam logic [7:0] OP_PTR_MAIN  = 8'h00;
  localparam logic [7:0] OP_PTR_SPARE = 8'h50;
  localparam logic [7:0] OP_LOAD      = 8'h80;
  localparam logic [7:0] OP_DUMMY     = 8'h11;
  localparam logic [7:0] OP_PROG      = 8'h10;
  localparam logic [7:0] OP_MSTAT     = 8'h71;

  typedef enum logic [3:0] {
    S_IDLE,
    S_LOAD,
    S_ADDR,
    S_DATA,
    S_CLOSE,
    S_WAIT,
    S_SCMD,
    S_SRD,
    S_SCAP
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_EMPTY = 2'd1,
    ERR_PTR   = 2'd2,
    ERR_TMO   = 2'd3
  } seq_err_e;

endpackage

// File: rtl/mpp_plane_pick.sv
module mpp_plane_pick #(
  parameter int NP = 4,
  localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic [NP-1:0] mask,
  input  logic [IW:0]   from,
  output logic          found,
  output logic [IW-1:0] idx
);

  logic [NP-1:0] elig;

  genvar i;
  generate
    for (i = 0; i < NP; i++) begin : g_elig
      assign elig[i] = mask[i] && (from <= (IW+1)'(i));
    end
  endgenerate

  always_comb begin
    found = |elig;
    idx   = '0;
    for (int k = NP - 1; k >= 0; k--) begin
      if (elig[k]) idx = IW'(k);
    end
  end

endmodule

// File: rtl/mpp_busy_wait.sv
module mpp_busy_wait #(
  parameter int GUARD   = 2,
  parameter int TMO_CYC = 4096,
  localparam int CW = $clog2(TMO_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic run,
  input  logic rdy,
  output logic ok,
  output logic expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || arm) begin
      cnt <= '0;
    end else if (run && cnt != CW'(TMO_CYC)) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    ok      = run && rdy && (cnt >= CW'(GUARD));
    expired = run && !ok && (cnt >= CW'(TMO_CYC - 1));
  end

endmodule

// File: rtl/mpp_seq.sv
module mpp_seq
  import mpp_pkg::*;
#(
  parameter int NP         = 4,
  parameter int PAGE_BYTES = 528,
  parameter int ROW_CYC    = 3,
  parameter int PG_W       = 5,
  parameter int GUARD      = 2,
  parameter int TMO_CYC    = 4096,
  localparam int IW    = (NP > 1) ? $clog2(NP) : 1,
  localparam int GRP_W = ROW_CYC * 8 - IW - PG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NP-1:0]    plane_mask,
  input  logic [1:0]       area_ptr,
  input  logic [GRP_W-1:0] blk_grp,
  input  logic [PG_W-1:0]  page_idx,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  output logic             s_ready,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err,
  output logic [NP-1:0]    fail_mask,
  output logic             any_fail,
  output logic             fl_cmd_we,
  output logic             fl_adr_we,
  output logic             fl_dat_we,
  output logic             fl_rd,
  output logic [7:0]       fl_io_out,
  input  logic [7:0]       fl_io_in,
  input  logic             fl_rdy
);

  localparam int ADR_CYC = ROW_CYC + 1;
  localparam int AW      = $clog2(ADR_CYC + 1);
  localparam int BW      = $clog2(PAGE_BYTES);
  localparam int ROW_W   = ROW_CYC * 8;

  seq_state_e       st;
  logic [NP-1:0]    mask_q;
  logic [GRP_W-1:0] grp_q;
  logic [PG_W-1:0]  page_q;
  logic [IW-1:0]    cur;
  logic [AW-1:0]    acnt;
  logic [BW-1:0]    bcnt;

  logic          first_found, nxt_found;
  logic [IW-1:0] first_idx, nxt_idx;
  logic          wait_ok, wait_exp;
  logic [ROW_W-1:0] row_w;
  logic [7:0]    adr_byte;
  logic          unused_stat;

  assign unused_stat = ^{fl_io_in[7:NP+1], first_found};

  mpp_plane_pick #(.NP(NP)) u_first (
    .mask  (plane_mask),
    .from  ('0),
    .found (first_found),
    .idx   (first_idx)
  );

  mpp_plane_pick #(.NP(NP)) u_next (
    .mask  (mask_q),
    .from  ({1'b0, cur} + (IW+1)'(1)),
    .found (nxt_found),
    .idx   (nxt_idx)
  );

  mpp_busy_wait #(.GUARD(GUARD), .TMO_CYC(TMO_CYC)) u_wait (
    .clk     (clk),
    .rst     (rst),
    .arm     (st == S_CLOSE),
    .run     (st == S_WAIT),
    .rdy     (fl_rdy),
    .ok      (wait_ok),
    .expired (wait_exp)
  );

  // Row: group above plane above page, so block = group*NP + plane.
  assign row_w = {grp_q, cur, page_q};

  always_comb begin
    adr_byte = 8'h00;
    for (int k = 1; k < ADR_CYC; k++) begin
      if (int'(acnt) == k) adr_byte = row_w[8*(k-1) +: 8];
    end
  end

  assign s_ready = (st == S_DATA);
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      mask_q    <= '0;
      grp_q     <= '0;
      page_q    <= '0;
      cur       <= '0;
      acnt      <= '0;
      bcnt      <= '0;
      done      <= 1'b0;
      err       <= ERR_NONE;
      fail_mask <= '0;
      any_fail  <= 1'b0;
      fl_cmd_we <= 1'b0;
      fl_adr_we <= 1'b0;
      fl_dat_we <= 1'b0;
      fl_rd     <= 1'b0;
      fl_io_out <= 8'h00;
    end else begin
      fl_cmd_we <= 1'b0;
      fl_adr_we <= 1'b0;
      fl_dat_we <= 1'b0;
      fl_rd     <= 1'b0;
      done      <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (area_ptr[0]) begin
              done      <= 1'b1;
              err       <= ERR_PTR;
              fail_mask <= '0;
              any_fail  <= 1'b0;
            end else if (plane_mask == '0) begin
              done      <= 1'b1;
              err       <= ERR_EMPTY;
              fail_mask <= '0;
              any_fail  <= 1'b0;
            end else begin
              mask_q    <= plane_mask;
              grp_q     <= blk_grp;
              page_q    <= page_idx;
              cur       <= first_idx;
              fl_cmd_we <= 1'b1;
              fl_io_out <= area_ptr[1] ? OP_PTR_SPARE : OP_PTR_MAIN;
              st        <= S_LOAD;
            end
          end
        end
        S_LOAD: begin
          fl_cmd_we <= 1'b1;
          fl_io_out <= OP_LOAD;
          acnt      <= '0;
          st        <= S_ADDR;
        end
        S_ADDR: begin
          fl_adr_we <= 1'b1;
          fl_io_out <= adr_byte;
          if (acnt == AW'(ADR_CYC - 1)) begin
            bcnt <= '0;
            st   <= S_DATA;
          end else begin
            acnt <= acnt + 1'b1;
          end
        end
        S_DATA: begin
          if (s_valid) begin
            fl_dat_we <= 1'b1;
            fl_io_out <= s_data;
            if (bcnt == BW'(PAGE_BYTES - 1)) begin
              st <= S_CLOSE;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
        end
        S_CLOSE: begin
          fl_cmd_we <= 1'b1;
          fl_io_out <= nxt_found ? OP_DUMMY : OP_PROG;
          st        <= S_WAIT;
        end
        S_WAIT: begin
          if (wait_ok) begin
            if (nxt_found) begin
              cur <= nxt_idx;
              st  <= S_LOAD;
            end else begin
              st <= S_SCMD;
            end
          end else if (wait_exp) begin
            done      <= 1'b1;
            err       <= ERR_TMO;
            fail_mask <= '0;
            any_fail  <= 1'b0;
            st        <= S_IDLE;
          end
        end
        S_SCMD: begin
          fl_cmd_we <= 1'b1;
          fl_io_out <= OP_MSTAT;
          st        <= S_SRD;
        end
        S_SRD: begin
          fl_rd <= 1'b1;
          st    <= S_SCAP;
        end
        S_SCAP: begin
          done      <= 1'b1;
          err       <= ERR_NONE;
          fail_mask <= fl_io_in[NP:1] & mask_q;
          any_fail  <= fl_io_in[0];
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mpp_seq_chk.sv
module mpp_seq_chk #(
  parameter int NP = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [7:0]    s_data,
  input logic          s_valid,
  input logic          s_ready,
  input logic          busy,
  input logic          done,
  input logic [1:0]    err,
  input logic [NP-1:0] fail_mask,
  input logic [NP-1:0] mask_q,
  input logic          fl_cmd_we,
  input logic          fl_adr_we,
  input logic          fl_dat_we,
  input logic          fl_rd,
  input logic [7:0]    fl_io_out,
  input logic          fl_rdy
);

  // R4
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fl_cmd_we, fl_adr_we, fl_dat_we, fl_rd}));

  // R7
  dat_src_chk: assert property (@(posedge clk) disable iff (rst)
    fl_dat_we |-> ($past(s_valid && s_ready) && fl_io_out == $past(s_data)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  fail_sub_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ((fail_mask & ~mask_q) == '0));

  // R11
  ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> busy);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2
  ptr_err_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err == 2'd2) |-> $past(start));

  // R3
  empty_err_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err == 2'd1) |-> $past(start));

  // R10
  tmo_err_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err == 2'd3) |-> $past(!fl_rdy));

endmodule

bind mpp_seq mpp_seq_chk #(.NP(NP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .s_data    (s_data),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .fail_mask (fail_mask),
  .mask_q    (mask_q),
  .fl_cmd_we (fl_cmd_we),
  .fl_adr_we (fl_adr_we),
  .fl_dat_we (fl_dat_we),
  .fl_rd     (fl_rd),
  .fl_io_out (fl_io_out),
  .fl_rdy    (fl_rdy)
);

// File: tb/tb_mpp_seq.sv
module tb_mpp_seq;

  localparam int PB = 528;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  plane_mask = '0;
  logic [1:0]  area_ptr = '0;
  logic [16:0] blk_grp = '0;
  logic [4:0]  page_idx = '0;
  logic [7:0]  s_data = '0;
  logic        s_valid = 1'b0;
  logic        s_ready, busy, done, any_fail;
  logic [1:0]  err;
  logic [3:0]  fail_mask;
  logic        fl_cmd_we, fl_adr_we, fl_dat_we, fl_rd;
  logic [7:0]  fl_io_out;
  logic [7:0]  fl_io_in = 8'h40;
  logic        fl_rdy = 1'b1;

  always #2 clk = ~clk;

  mpp_seq dut (
    .clk(clk), .rst(rst), .start(start), .plane_mask(plane_mask),
    .area_ptr(area_ptr), .blk_grp(blk_grp), .page_idx(page_idx),
    .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready), .busy(busy),
    .done(done), .err(err), .fail_mask(fail_mask), .any_fail(any_fail),
    .fl_cmd_we(fl_cmd_we), .fl_adr_we(fl_adr_we), .fl_dat_we(fl_dat_we),
    .fl_rd(fl_rd), .fl_io_out(fl_io_out), .fl_io_in(fl_io_in), .fl_rdy(fl_rdy)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- flash model (negedge) ----------------
  logic [7:0] cmd_log [0:31];
  logic [7:0] adr_log [0:31];
  int cmd_n, adr_n, dat_n, dat_bad, rd_n, viol, strobe_n;
  int busy_left;
  bit pend, hang;
  int pend_len;

  task automatic clear_model();
    cmd_n = 0; adr_n = 0; dat_n = 0; dat_bad = 0; rd_n = 0;
    viol = 0; strobe_n = 0; busy_left = 0; pend = 0; hang = 0;
    fl_rdy = 1'b1;
  endtask

  initial begin
    clear_model();
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (fl_cmd_we || fl_adr_we || fl_dat_we || fl_rd) begin
          strobe_n++;
          if (pend || !fl_rdy) viol++;
        end
        if (pend) begin
          pend = 0;
          fl_rdy = 1'b0;
          busy_left = pend_len;
        end else if (!fl_rdy && !hang) begin
          busy_left--;
          if (busy_left <= 0) fl_rdy = 1'b1;
        end
        if (fl_cmd_we) begin
          if (cmd_n < 32) cmd_log[cmd_n] = fl_io_out;
          cmd_n++;
          if (fl_io_out == 8'h11) begin pend = 1; pend_len = 3; end
          if (fl_io_out == 8'h10) begin pend = 1; pend_len = 20; end
        end
        if (fl_adr_we) begin
          if (adr_n < 32) adr_log[adr_n] = fl_io_out;
          adr_n++;
        end
        if (fl_dat_we) begin
          if (fl_io_out != 8'((dat_n * 7 + 3) & 255)) dat_bad++;
          dat_n++;
        end
        if (fl_rd) rd_n++;
      end
    end
  end

  // ---------------- payload feeder (negedge) ----------------
  int f_idx = 0;
  int f_tick = 0;
  bit stall_en = 0;

  initial begin
    forever begin
      @(negedge clk);
      f_tick++;
      s_data  = 8'((f_idx * 7 + 3) & 255);
      s_valid = !stall_en || ((f_tick % 4) != 2);
      if (s_valid && s_ready) f_idx++;
    end
  end

  // ---------------- helpers ----------------
  int d_cyc;
  logic [1:0] d_err;
  logic [3:0] d_fm;
  logic d_any;

  task automatic issue(input logic [3:0] m, input logic [1:0] p);
    @(negedge clk);
    plane_mask = m; area_ptr = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    d_cyc = 1;
    while (!done && d_cyc < limit) begin
      @(negedge clk);
      d_cyc++;
    end
    d_err = err; d_fm = fail_mask; d_any = any_fail;
    if (!done) chk(0, "done timeout", d_cyc, limit);
  endtask

  function automatic int row_of(input int p);
    return (int'(blk_grp) << 7) | (p << 5) | int'(page_idx);
  endfunction

  task automatic chk_seq(input logic [3:0] m, input logic [1:0] p, input bit with_stat);
    logic [7:0] ec [0:15];
    logic [7:0] ea [0:31];
    int nc = 0, na = 0, hi = 0, np = 0;
    bit okc, oka;
    for (int i = 0; i < 4; i++) if (m[i]) begin hi = i; np++; end
    ec[nc++] = (p == 2'd2) ? 8'h50 : 8'h00;
    for (int i = 0; i < 4; i++) begin
      if (m[i]) begin
        ec[nc++] = 8'h80;
        ec[nc++] = (i == hi) ? 8'h10 : 8'h11;
        ea[na++] = 8'h00;
        for (int b = 0; b < 3; b++) ea[na++] = 8'((row_of(i) >> (8 * b)) & 255);
      end
    end
    if (with_stat) ec[nc++] = 8'h71;
    okc = (cmd_n == nc);
    for (int i = 0; i < nc && okc; i++) if (cmd_log[i] != ec[i]) okc = 0;
    chk(okc, "R4 R5 command order", cmd_n, nc);
    oka = (adr_n == na);
    for (int i = 0; i < na && oka; i++) if (adr_log[i] != ea[i]) oka = 0;
    chk(oka, "R6 address bytes", adr_n, na);
    chk(dat_n == np * PB, "R7 data byte count", dat_n, np * PB);
    chk(dat_bad == 0, "R7 data byte order", dat_bad, 0);
    chk(viol == 0, "R8 strobe during busy", viol, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(!busy && !done && !s_ready, "R1 idle outputs", {busy, done, s_ready}, 0);
    chk(strobe_n == 0 && !fl_cmd_we && !fl_adr_we && !fl_dat_we && !fl_rd,
        "R1 no strobes", strobe_n, 0);
  endtask

  task automatic t_four_planes();
    clear_model(); f_idx = 0; stall_en = 0;
    blk_grp = 17'h1A5C3; page_idx = 5'd9; fl_io_in = 8'h40 | 8'h02;
    issue(4'hF, 2'd0);
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    repeat (40) @(negedge clk);
    start = 1'b1; plane_mask = 4'h0; area_ptr = 2'd1;
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R11 start ignored while busy", done, 0);
    plane_mask = 4'hF; area_ptr = 2'd0;
    wait_done(20000);
    chk_seq(4'hF, 2'd0, 1);
    chk(rd_n == 1, "R9 one status read", rd_n, 1);
    chk(d_err == 2'd0 && d_fm == 4'h1 && d_any == 1'b0, "R9 status decode plane0",
        {d_err, d_fm, d_any}, {2'd0, 4'h1, 1'b0});
  endtask

  task automatic t_sparse();
    clear_model(); f_idx = 0; stall_en = 1;
    blk_grp = 17'h00F0F; page_idx = 5'd31; fl_io_in = 8'h47;
    issue(4'hA, 2'd2);
    wait_done(20000);
    chk_seq(4'hA, 2'd2, 1);
    chk(d_fm == 4'h2 && d_any == 1'b1 && d_err == 2'd0, "R9 fail masked to selection",
        {d_err, d_fm, d_any}, {2'd0, 4'h2, 1'b1});
    stall_en = 0;
  endtask

  task automatic t_single();
    clear_model(); f_idx = 0;
    blk_grp = 17'h10001; page_idx = 5'd0; fl_io_in = 8'h49;
    issue(4'h4, 2'd0);
    wait_done(20000);
    chk_seq(4'h4, 2'd0, 1);
    chk(d_fm == 4'h4 && d_any == 1'b1, "R9 plane2 fail", {d_fm, d_any}, {4'h4, 1'b1});
  endtask

  task automatic t_empty();
    clear_model();
    issue(4'h0, 2'd0);
    wait_done(10);
    chk(d_cyc == 1 && d_err == 2'd1, "R3 empty mask", {d_cyc, d_err}, {32'd1, 2'd1});
    repeat (3) @(negedge clk);
    chk(strobe_n == 0 && !busy, "R3 no strobes", strobe_n, 0);
  endtask

  task automatic t_bad_ptr();
    clear_model();
    issue(4'hF, 2'd1);
    wait_done(10);
    chk(d_cyc == 1 && d_err == 2'd2 && d_fm == 4'h0, "R2 pointer 1 refused", d_err, 2);
    issue(4'h0, 2'd3);
    wait_done(10);
    chk(d_err == 2'd2, "R2 pointer check before mask", d_err, 2);
    repeat (3) @(negedge clk);
    chk(strobe_n == 0, "R2 no strobes", strobe_n, 0);
  endtask

  task automatic t_timeout();
    clear_model(); f_idx = 0; hang = 1;
    fl_io_in = 8'h40;
    issue(4'h1, 2'd0);
    wait_done(20000);
    chk(d_err == 2'd3 && d_fm == 4'h0, "R10 timeout error", d_err, 3);
    repeat (5) @(negedge clk);
    chk(cmd_n == 3 && cmd_log[2] == 8'h10 && rd_n == 0, "R10 no status after timeout",
        cmd_n, 3);
    clear_model();
  endtask

  // ---------------- main + watchdog ----------------
  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_four_planes();
    t_sparse();
    t_single();
    t_empty();
    t_bad_ptr();
    t_timeout();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule